// File: doc/BRIEF.md
# Complex Quarter-Rate Bandpass Lattice Ladder Filter

This block separates the in-phase and quadrature content of a real intermediate-frequency sample stream. A fifth-order lattice ladder low-pass prototype is used, and every delay in it is followed by a rotation by j. The rotation moves the passband centre from DC to one quarter of the sample rate. The negative-frequency image is rejected, and the block emits one complex (I, Q) sample for each real input sample.

The prototype has two branches that run side by side. One branch is a chain of three complex state nodes and the other is a chain of two. Each node forms one loop: its state is rotated, scaled by a fixed 7-bit coefficient, added to the node's input, rounded toward zero and saturated, all in that node's own integer and fraction width. Because the centre is exactly fs/4, the rotation needs no multiplier. It is a swap of the real and imaginary parts with one negation. The output register combines the ends of the two branches by a halved sum (I) and a halved difference (Q). A decimator and mixer placed after this block take these samples.

Top module: `cbp_lattice_filter`

## Requirements
- R1: A synchronous active-low reset clears all node states and the output register, with out_valid, out_i and out_q at 0. Reset has priority over in_valid in the same cycle.
- R2: Each cycle with in_valid high gives exactly one cycle of out_valid high at the next clock edge. Cycles without in_valid give out_valid low.
- R3: In each node the held complex state (re, im) is first rotated to (-im, re). It is then multiplied by the node's coefficient, valued c/64 for a 7-bit signed c, and the product is truncated toward minus infinity to 12 fraction bits. The result is added to the node's input. The default coefficients are 38, -45, 27 for the three-node branch and -52, 33 for the two-node branch.
- R4: The node sum is rounded toward zero to the node's fraction width. It is then saturated symmetrically to ±(2^(IB+FB)-1)/2^FB. (IB, FB) are (0,11), (1,10), (1,11) along the three-node branch and (0,11), (1,10) along the two-node branch, so the most negative code is never held.
- R5: The first node of each branch takes the input sample as a 12-fraction-bit real value with zero imaginary part. Every later node takes the value its predecessor held before the current update. All nodes update together on in_valid.
- R6: On each in_valid, out_i becomes (Ure + Lre) >> 1 and out_q becomes (Uim - Lim) >> 1, both arithmetic shifts. U and L are the end nodes of the three-node and two-node branches, aligned to 12 fraction bits and taken before the current update. Each result is saturated to ±4095, so -4096 never appears.
- R7: Idle cycles between samples change no state and no output. The output sequence depends only on the sequence of valid samples.
- R8: A full-scale input at the passband centre drives the node saturation. The outputs then still match R3 to R6 exactly and stay within ±4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 13 | Real input, signed, 12 fraction bits |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 13 | In-phase output, signed, 12 fraction bits |
| out_q | output | 13 | Quadrature output, signed, 12 fraction bits |

## Verification
On every valid edge the output register reads the branch end states at the same moment those states are overwritten. The output must therefore reflect the values from before the update, while the nodes take their new values. This is provoked by streams of back-to-back valid samples and by sparse streams with idle gaps. Every output is judged against a bit-exact model that keeps the same read-before-write order. Reset arriving together with a valid sample is also driven, and the result is judged by a cleared output and a cleared state afterwards.

// File: rtl/cbp_pkg.sv
// Shared widths and per-node formats for the complex bandpass lattice filter.
// Assumes WORK_FRAC equals SIG_W-1, so the input and the output share one scale.
package cbp_pkg;
    localparam int SIG_W     = 13;   // input/output sample width
    localparam int COEF_W    = 7;    // coefficient width incl. sign
    localparam int COEF_FRAC = 6;    // coefficient fraction bits
    localparam int WORK_FRAC = 12;   // common working fraction bits
    localparam int WORK_W    = 16;   // sign + 3 integer + 12 fraction
    localparam int NODE_CNT  = 5;    // total nodes, both branches
    localparam int UP_N      = 3;    // nodes in the longer branch
    localparam int LO_N      = 2;    // nodes in the shorter branch

    // Per-node integer bits (without sign) and fraction bits; long branch first.
    localparam int NODE_IB [NODE_CNT] = '{0, 1, 1, 0, 1};
    localparam int NODE_FB [NODE_CNT] = '{11, 10, 11, 11, 10};

    localparam logic signed [COEF_W-1:0] DEF_COEFS [NODE_CNT] =
        '{7'sd38, -7'sd45, 7'sd27, -7'sd52, 7'sd33};
endpackage

// File: rtl/cbp_node.sv
// One complex loop node: state rotated by j, scaled by a fixed coefficient,
// product truncated toward minus infinity, added to the node input, then
// rounded toward zero and saturated symmetrically into the node's own format.
// Assumes FB <= WORK_FRAC. Output is the held state aligned to WORK_FRAC.
module cbp_node
    import cbp_pkg::*;
#(
    parameter int IB = 0,
    parameter int FB = 11,
    parameter logic signed [COEF_W-1:0] COEF = 7'sd0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [WORK_W-1:0] in_re,
    input  logic signed [WORK_W-1:0] in_im,
    output logic signed [WORK_W-1:0] st_re,
    output logic signed [WORK_W-1:0] st_im
);
    localparam int SW  = 1 + IB + FB;
    localparam int D   = WORK_FRAC - FB;
    localparam int MW  = WORK_W + COEF_W;
    localparam int UW  = WORK_W + 1;
    localparam int LIM = (1 << (SW - 1)) - 1;
    localparam logic [UW-1:0] RMASK = UW'((1 << D) - 1);

    logic signed [SW-1:0]     s_re, s_im, nx_re, nx_im;
    logic signed [WORK_W-1:0] al_re, al_im, r_re, r_im, p_re, p_im;
    logic signed [MW-1:0]     m_re, m_im;
    logic signed [UW-1:0]     u_re, u_im;

    // Round toward zero by D bits, then clamp to the symmetric node range.
    function automatic logic signed [SW-1:0] settle(input logic signed [UW-1:0] u);
        logic signed [UW-1:0] q;
        q = u >>> D;
        if (u[UW-1] && ((u & RMASK) != '0))
            q = q + UW'(1);
        if (q > UW'(LIM))
            return SW'(LIM);
        else if (q < UW'(-LIM))
            return SW'(-LIM);
        else
            return SW'(q);
    endfunction

    // Datapath: align, rotate by j, multiply, truncate, add, settle.
    always_comb begin
        al_re = WORK_W'(s_re) <<< D;
        al_im = WORK_W'(s_im) <<< D;
        r_re  = -al_im;
        r_im  = al_re;
        m_re  = MW'(r_re) * MW'(COEF);
        m_im  = MW'(r_im) * MW'(COEF);
        p_re  = WORK_W'(m_re >>> COEF_FRAC);
        p_im  = WORK_W'(m_im >>> COEF_FRAC);
        u_re  = UW'(in_re) + UW'(p_re);
        u_im  = UW'(in_im) + UW'(p_im);
        nx_re = settle(u_re);
        nx_im = settle(u_im);
    end

    // State register: cleared by reset, loaded only on a valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_re <= '0;
            s_im <= '0;
        end else if (en) begin
            s_re <= nx_re;
            s_im <= nx_im;
        end
    end

    assign st_re = al_re;
    assign st_im = al_im;

    // R4: saturation is symmetric, the most negative code is never held.
    assert_sym_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_re != {1'b1, {(SW-1){1'b0}}}) && (s_im != {1'b1, {(SW-1){1'b0}}}));

    // R7: without a valid sample the state does not move.
    assert_idle_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(s_re) && $stable(s_im)));
endmodule

// File: rtl/cbp_ladder.sv
// A chain of N complex nodes. Node 0 takes the branch input and every later
// node takes its predecessor's held state, so each stage adds one sample delay.
// Node formats and coefficients are taken from index BASE onward.
module cbp_ladder
    import cbp_pkg::*;
#(
    parameter int N    = UP_N,
    parameter int BASE = 0,
    parameter logic signed [COEF_W-1:0] COEFS [NODE_CNT] = DEF_COEFS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [WORK_W-1:0] in_re,
    input  logic signed [WORK_W-1:0] in_im,
    output logic signed [WORK_W-1:0] tail_re,
    output logic signed [WORK_W-1:0] tail_im
);
    logic signed [WORK_W-1:0] ch_re [N+1];
    logic signed [WORK_W-1:0] ch_im [N+1];

    assign ch_re[0] = in_re;
    assign ch_im[0] = in_im;

    // One node per stage, formats picked from the package tables.
    for (genvar k = 0; k < N; k++) begin : g_node
        cbp_node #(
            .IB  (NODE_IB[BASE+k]),
            .FB  (NODE_FB[BASE+k]),
            .COEF(COEFS[BASE+k])
        ) u_node (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (en),
            .in_re(ch_re[k]),
            .in_im(ch_im[k]),
            .st_re(ch_re[k+1]),
            .st_im(ch_im[k+1])
        );
    end

    assign tail_re = ch_re[N];
    assign tail_im = ch_im[N];
endmodule

// File: rtl/cbp_combiner.sv
// Output stage: halved sum of the branch ends gives I, halved difference of
// the imaginary parts gives Q. Both use an arithmetic shift, are saturated to
// a symmetric SIG_W range and are registered with one strobe per valid.
// Assumes the inputs carry WORK_FRAC = SIG_W-1 fraction bits.
module cbp_combiner
    import cbp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [WORK_W-1:0] up_re,
    input  logic signed [WORK_W-1:0] up_im,
    input  logic signed [WORK_W-1:0] lo_re,
    input  logic signed [WORK_W-1:0] lo_im,
    output logic                     out_valid,
    output logic signed [SIG_W-1:0]  out_i,
    output logic signed [SIG_W-1:0]  out_q
);
    localparam int SUMW = WORK_W + 1;
    localparam int OLIM = (1 << (SIG_W - 1)) - 1;

    logic signed [SUMW-1:0] h_i, h_q;
    logic signed [SIG_W-1:0] c_i, c_q;

    // Clamp a halved value to the symmetric output range.
    function automatic logic signed [SIG_W-1:0] clip(input logic signed [SUMW-1:0] v);
        if (v > SUMW'(OLIM))
            return SIG_W'(OLIM);
        else if (v < SUMW'(-OLIM))
            return SIG_W'(-OLIM);
        else
            return SIG_W'(v);
    endfunction

    // Sum and difference of the branch ends, halved and clamped.
    always_comb begin
        h_i = (SUMW'(up_re) + SUMW'(lo_re)) >>> 1;
        h_q = (SUMW'(up_im) - SUMW'(lo_im)) >>> 1;
        c_i = clip(h_i);
        c_q = clip(h_q);
    end

    // Output register: loads on a valid sample, strobe follows the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= en;
            if (en) begin
                out_i <= c_i;
                out_q <= c_q;
            end
        end
    end

    // R2: a valid sample yields a strobe on the next edge.
    assert_strobe_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> out_valid);

    // R2: no strobe without a valid sample.
    assert_strobe_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out_valid);

    // R6: the most negative output code never appears.
    assert_out_sym_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_i != {1'b1, {(SIG_W-1){1'b0}}}) && (out_q != {1'b1, {(SIG_W-1){1'b0}}}));

    // R7: outputs hold through idle cycles.
    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(out_i) && $stable(out_q)));
endmodule

// File: rtl/cbp_lattice_filter.sv
// Top of the complex quarter-rate bandpass filter. The real input feeds both
// lattice branches with zero imaginary part, and the combiner forms the I/Q output.
// Assumes the input sample is a pure fraction with SIG_W-1 fraction bits.
module cbp_lattice_filter
    import cbp_pkg::*;
#(
    parameter logic signed [COEF_W-1:0] COEFS [NODE_CNT] = DEF_COEFS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [SIG_W-1:0] in_sample,
    output logic                    out_valid,
    output logic signed [SIG_W-1:0] out_i,
    output logic signed [SIG_W-1:0] out_q
);
    logic signed [WORK_W-1:0] x_re, x_im;
    logic signed [WORK_W-1:0] u_re, u_im, l_re, l_im;

    assign x_re = WORK_W'(in_sample);
    assign x_im = '0;

    cbp_ladder #(.N(UP_N), .BASE(0), .COEFS(COEFS)) u_upper (
        .clk(clk), .rst_n(rst_n), .en(in_valid),
        .in_re(x_re), .in_im(x_im),
        .tail_re(u_re), .tail_im(u_im)
    );

    cbp_ladder #(.N(LO_N), .BASE(UP_N), .COEFS(COEFS)) u_lower (
        .clk(clk), .rst_n(rst_n), .en(in_valid),
        .in_re(x_re), .in_im(x_im),
        .tail_re(l_re), .tail_im(l_im)
    );

    cbp_combiner u_comb (
        .clk(clk), .rst_n(rst_n), .en(in_valid),
        .up_re(u_re), .up_im(u_im), .lo_re(l_re), .lo_im(l_im),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );
endmodule

// File: tb/cbp_lattice_filter_test.sv
module cbp_lattice_filter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [12:0] in_sample = '0;
    logic out_valid;
    logic signed [12:0] out_i, out_q;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cbp_lattice_filter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    // Reference model values from the requirements (R3, R4).
    localparam int M_IB [5] = '{0, 1, 1, 0, 1};
    localparam int M_FB [5] = '{11, 10, 11, 11, 10};
    localparam int M_CF [5] = '{38, -45, 27, -52, 33};
    int ms_re [5];
    int ms_im [5];

    // Stimulus table: sample value and idle cycles after it.
    localparam int NV = 20;
    localparam int STIM [NV][2] = '{
        '{1200, 0}, '{-800, 0}, '{3000, 1}, '{-4096, 0}, '{4095, 2},
        '{0, 0}, '{-1, 0}, '{1, 3}, '{2047, 0}, '{-2048, 0},
        '{512, 1}, '{-3333, 0}, '{100, 0}, '{-100, 2}, '{4000, 0},
        '{-4000, 0}, '{77, 1}, '{-5, 0}, '{0, 4}, '{1500, 0}
    };

    function automatic int clampv(input int v, input int lim);
        if (v > lim) return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 5; k++) begin
            ms_re[k] = 0;
            ms_im[k] = 0;
        end
    endtask

    // One valid sample: output from pre-update ends (R6), then node updates (R3-R5).
    task automatic model_step(input int x, output int ei, output int eq);
        int nre [5];
        int nim [5];
        int ur, ui, lr, li;
        ur = ms_re[2] * (1 << (12 - M_FB[2]));
        ui = ms_im[2] * (1 << (12 - M_FB[2]));
        lr = ms_re[4] * (1 << (12 - M_FB[4]));
        li = ms_im[4] * (1 << (12 - M_FB[4]));
        ei = clampv((ur + lr) >>> 1, 4095);
        eq = clampv((ui - li) >>> 1, 4095);
        for (int k = 0; k < 5; k++) begin
            int inr, ini, ar, ai, pr, pi, sr, si, d, lim;
            if (k == 0 || k == 3) begin
                inr = x;
                ini = 0;
            end else begin
                inr = ms_re[k-1] * (1 << (12 - M_FB[k-1]));
                ini = ms_im[k-1] * (1 << (12 - M_FB[k-1]));
            end
            d  = 12 - M_FB[k];
            ar = ms_re[k] * (1 << d);
            ai = ms_im[k] * (1 << d);
            pr = ((-ai) * M_CF[k]) >>> 6;
            pi = (ar * M_CF[k]) >>> 6;
            sr = (inr + pr) / (1 << d);
            si = (ini + pi) / (1 << d);
            lim = (1 << (M_IB[k] + M_FB[k])) - 1;
            nre[k] = clampv(sr, lim);
            nim[k] = clampv(si, lim);
        end
        for (int k = 0; k < 5; k++) begin
            ms_re[k] = nre[k];
            ms_im[k] = nim[k];
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Drive one sample at a falling edge, judge the output one edge later.
    task automatic send(input int x, input int gap, input string req);
        int ei, eq;
        model_step(x, ei, eq);
        in_valid  = 1'b1;
        in_sample = 13'(x);
        @(negedge clk);
        chk(out_valid == 1'b1, "R2 strobe", int'(out_valid), 1);
        chk(int'(out_i) == ei, {req, " I"}, int'(out_i), ei);
        chk(int'(out_q) == eq, {req, " Q"}, int'(out_q), eq);
        chk(int'(out_i) != -4096 && int'(out_q) != -4096, "R6 range", int'(out_i), ei);
        in_valid = 1'b0;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R2 idle strobe", int'(out_valid), 0);
            chk(int'(out_i) == ei && int'(out_q) == eq, "R7 idle hold", int'(out_i), ei);
        end
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int seed;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 reset strobe", int'(out_valid), 0);
        chk(out_i == 0 && out_q == 0, "R1 reset outputs", int'(out_i), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: mixed samples and gaps (R3, R5, R7)
        for (int i = 0; i < NV; i++)
            send(STIM[i][0], STIM[i][1], "R3 table");

        // Impulse and its tail, with varying gaps (R5, R7)
        send(2048, 0, "R5 impulse");
        for (int i = 0; i < 70; i++)
            send(0, i % 3, "R5 tail");

        // Full-scale tone at fs/4 drives saturation (R4, R8)
        for (int i = 0; i < 60; i++) begin
            case (i % 4)
                0: send(4095, 0, "R8 tone");
                1: send(0, 0, "R8 tone");
                2: send(-4096, 0, "R4 tone");
                default: send(0, 0, "R4 tone");
            endcase
        end

        // Reset together with a valid sample while state is nonzero (R1)
        in_valid  = 1'b1;
        in_sample = 13'sd3000;
        rst_n     = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        chk(out_valid == 1'b0, "R1 reset over valid", int'(out_valid), 0);
        chk(out_i == 0 && out_q == 0, "R1 cleared outputs", int'(out_q), 0);
        model_reset();
        for (int i = 0; i < 4; i++)
            send(0, 0, "R1 cleared state");

        // Back-to-back pseudo-random stream (R2, R6)
        seed = 7;
        for (int i = 0; i < 40; i++) begin
            seed = seed * 1103515245 + 12345;
            send((seed >>> 16) % 4096, 0, "R6 stream");
        end

        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R2 final idle", int'(out_valid), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule